// File: doc/BRIEF.md
# Input Presence Probe Sequencer

This block decides whether the power-stage input rail of a buck converter is alive before the converter starts. It stays idle until the bias supply is reported valid and the enable pin is released. It then requests the high-side switch for a short pulse at a fixed repetition rate. A comparator outside the block reports whether the switch node sits above its 1.5 V threshold. That flag reaches the block asynchronously. It is synchronized, and each rising or falling change of it is counted as one crossing.

When the required number of crossings has been seen, the block raises its ready output for the soft-start logic and stops probing. Ready then stays high while the block remains enabled. Losing the bias supply, or pulling the enable pin low, returns the block to idle. That also clears the probe timer and the crossing count. The pulse width and the period are given in clock cycles. By default they come from the clock frequency, to give 1 us pulses every 100 us.

Top module: `prb_rail_probe`

## Requirements
- R1: While reset is asserted and after its release, with no enable, `probe_gate` and `rail_ready` are 0.
- R2: Probing runs only while `bias_ok`=1 and `dis_n`=1. Both are synchronous inputs. `probe_gate` goes high in the first cycle after the clock edge that samples both high.
- R3: Each probe pulse holds `probe_gate` high for exactly PULSE_CYC clock cycles.
- R4: Consecutive probe pulses start PERIOD_CYC clock cycles apart.
- R5: Every change of `sw_hi` while probing counts as one crossing, whether 0 to 1 or 1 to 0. With SYNC_STAGES=2, `rail_ready` rises on the third clock edge after the CROSS_NEED-th change.
- R6: Once `rail_ready` is 1 and the block stays enabled, `probe_gate` stays 0, `rail_ready` stays 1, and changes of `sw_hi` have no effect.
- R7: If `bias_ok` or `dis_n` is sampled low, both outputs are 0 after that edge. The crossing count restarts from zero at the next enable.
- R8: Changes of `sw_hi` while the block is not probing are not counted.
- R9: If `sw_hi` never changes, probing repeats indefinitely and `rail_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Bias supply power-on-reset released (1 = valid) |
| dis_n | input | 1 | Enable pin level (0 = pulled low, block disabled) |
| sw_hi | input | 1 | Asynchronous switch-node-above-threshold flag |
| probe_gate | output | 1 | High-side switch request during a probe pulse |
| rail_ready | output | 1 | Input rail recognised, hand-over to soft start |

## Verification
The hardest case to reach is a partly filled crossing count that must be discarded. A plain sequence of enable and rail pulses always runs to the full count and hides a missed clear. The bench therefore drives the switch-node flag directly. It stops one crossing short, then drops enable or the bias flag. After re-enabling, it shows that one more crossing leaves ready low and that a full new set is needed. Exact ready latency is measured by sampling the cycles just before and on the third edge after the final change.

// File: rtl/prb_pkg.sv
package prb_pkg;
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_PROBE = 2'd1,
    PS_READY = 2'd2
  } prb_state_e;
endpackage

// File: rtl/prb_sync_edge.sv
module prb_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_seen
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // synchronizer chain, one flop per stage
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign edge_seen = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/prb_probe_timer.sv
module prb_probe_timer #(
  parameter int PULSE_CYC  = 100,
  parameter int PERIOD_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pulse_on
);
  localparam int TW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [TW-1:0] LAST  = TW'(PERIOD_CYC - 1);
  localparam logic [TW-1:0] WIDTH = TW'(PULSE_CYC);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pulse_on = run && (cnt_q < WIDTH);
endmodule

// File: rtl/prb_cross_count.sv
module prb_cross_count #(
  parameter int NEED = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int CW = $clog2(NEED + 1);
  localparam logic [CW-1:0] LAST = CW'(NEED - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr || inc;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = !clr && inc && (cnt_q == LAST);
endmodule

// File: rtl/prb_rail_probe.sv
module prb_rail_probe
  import prb_pkg::*;
#(
  parameter int CLK_KHZ     = 100000,
  parameter int PULSE_CYC   = CLK_KHZ / 1000,
  parameter int PERIOD_CYC  = CLK_KHZ / 10,
  parameter int CROSS_NEED  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bias_ok,
  input  logic dis_n,
  input  logic sw_hi,
  output logic probe_gate,
  output logic rail_ready
);
  prb_state_e state_q, state_d;
  logic       enabled;
  logic       probing;
  logic       sw_edge;
  logic       pulse_on;
  logic       count_done;

  assign enabled = bias_ok && dis_n;
  assign probing = (state_q == PS_PROBE);

  prb_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sw_hi), .edge_seen(sw_edge)
  );

  prb_probe_timer #(.PULSE_CYC(PULSE_CYC), .PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(probing), .pulse_on(pulse_on)
  );

  prb_cross_count #(.NEED(CROSS_NEED)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(!probing), .inc(sw_edge), .done(count_done)
  );

  always_comb begin
    state_d = state_q;
    if (!enabled) begin
      state_d = PS_IDLE;
    end else begin
      case (state_q)
        PS_IDLE:  state_d = PS_PROBE;
        PS_PROBE: if (count_done) state_d = PS_READY;
        PS_READY: state_d = PS_READY;
        default:  state_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_d;
  end

  assign probe_gate = pulse_on;
  assign rail_ready = (state_q == PS_READY);
endmodule

// File: rtl/prb_rail_probe_chk.sv
module prb_rail_probe_chk #(
  parameter int PULSE_CYC = 100
) (
  input logic clk,
  input logic rst_n,
  input logic bias_ok,
  input logic dis_n,
  input logic probe_gate,
  input logic rail_ready
);
  logic [31:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          high_cnt <= '0;
    else if (probe_gate) high_cnt <= high_cnt + 1;
    else                 high_cnt <= '0;
  end

  // R3: a pulse never outlasts its width
  a_r3_width_max: assert property (@(posedge clk) disable iff (!rst_n)
    probe_gate |-> (high_cnt < PULSE_CYC));

  // R3: a pulse that ends naturally has the full width
  a_r3_width_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(probe_gate) && !rail_ready && bias_ok && dis_n) |-> (high_cnt == PULSE_CYC));

  // R6: ready and probing never overlap
  a_r6_no_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rail_ready |-> !probe_gate);

  // R6: ready holds while enabled
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_ready && bias_ok && dis_n) |=> rail_ready);

  // R7: disable clears both outputs on the next edge
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!bias_ok || !dis_n) |=> (!rail_ready && !probe_gate));

  // R2: ready only arises from an enabled cycle
  a_r2_ready_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_ready) |-> $past(bias_ok && dis_n));
endmodule

bind prb_rail_probe prb_rail_probe_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .dis_n(dis_n),
  .probe_gate(probe_gate), .rail_ready(rail_ready)
);

// File: tb/sim_prb_rail_probe.sv
`timescale 1ns/1ps
module sim_prb_rail_probe;
  localparam int PW = 4;
  localparam int PP = 20;

  logic clk, rst_n, bias_ok, dis_n, sw_man, auto_mode, rail_on;
  logic sw_hi, probe_gate, rail_ready;
  int checks, errors;
  bit done;

  assign sw_hi = auto_mode ? (rail_on & probe_gate) : sw_man;

  prb_rail_probe #(.PULSE_CYC(PW), .PERIOD_CYC(PP), .CROSS_NEED(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .dis_n(dis_n),
    .sw_hi(sw_hi), .probe_gate(probe_gate), .rail_ready(rail_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic b; logic e; logic r; logic [7:0] cyc; logic exp; logic [7:0] req;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 1'b1, 8'd10, 1'b0, 8'd2},  // R2 both low
    '{1'b1, 1'b0, 1'b1, 8'd10, 1'b0, 8'd2},  // R2 pin pulled low
    '{1'b0, 1'b1, 1'b1, 8'd10, 1'b0, 8'd2},  // R2 bias invalid
    '{1'b1, 1'b1, 1'b0, 8'd100, 1'b0, 8'd9}, // R9 rail absent
    '{1'b1, 1'b1, 1'b1, 8'd50, 1'b1, 8'd5},  // R5 rail present
    '{1'b1, 1'b0, 1'b1, 8'd5, 1'b0, 8'd7},   // R7 disable
    '{1'b1, 1'b1, 1'b1, 8'd50, 1'b1, 8'd5},  // R5 again
    '{1'b0, 1'b1, 1'b1, 8'd5, 1'b0, 8'd7}    // R7 bias loss
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic toggle_sw();
    sw_man = ~sw_man;
    cyc(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int hi, per, gate_seen;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; bias_ok = 1'b0; dis_n = 1'b0;
    sw_man = 1'b0; auto_mode = 1'b1; rail_on = 1'b0;
    cyc(3);
    chk("R1 gate in reset", probe_gate, 0);
    chk("R1 ready in reset", rail_ready, 0);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 gate after reset", probe_gate, 0);
    chk("R1 ready after reset", rail_ready, 0);

    foreach (VEC[i]) begin
      bias_ok = VEC[i].b; dis_n = VEC[i].e; rail_on = VEC[i].r;
      gate_seen = 0;
      for (int k = 0; k < VEC[i].cyc; k++) begin
        @(negedge clk);
        if (probe_gate) gate_seen++;
      end
      chk($sformatf("R%0d vector %0d ready", VEC[i].req, i), rail_ready, VEC[i].exp);
      if (!(VEC[i].b && VEC[i].e))
        chk($sformatf("R%0d vector %0d no probe", VEC[i].req, i), gate_seen > 1, 0);
    end

    // R2 start latency, R3 width, R4 period (rail absent)
    bias_ok = 1'b0; rail_on = 1'b0; cyc(3);
    bias_ok = 1'b1; dis_n = 1'b1;
    @(negedge clk);
    chk("R2 first probe cycle", probe_gate, 1);
    hi = 1;
    while (probe_gate && hi < 50) begin @(negedge clk); if (probe_gate) hi++; end
    chk("R3 pulse width", hi, PW);
    per = hi;
    while (!probe_gate && per < 100) begin @(negedge clk); per++; end
    chk("R4 pulse period", per, PP);

    // R5 exact crossings and latency, manual flag
    auto_mode = 1'b0; sw_man = 1'b0;
    dis_n = 1'b0; cyc(2); dis_n = 1'b1; cyc(2);
    toggle_sw(); toggle_sw(); toggle_sw();
    chk("R5 three crossings not enough", rail_ready, 0);
    sw_man = ~sw_man;
    cyc(2);
    chk("R5 not ready two edges after fourth", rail_ready, 0);
    cyc(1);
    chk("R5 ready three edges after fourth", rail_ready, 1);

    // R6 ready holds, probe off, flag ignored
    gate_seen = 0;
    for (int k = 0; k < 2*PP; k++) begin
      @(negedge clk);
      if (probe_gate) gate_seen++;
      if (k % 5 == 0) sw_man = ~sw_man;
    end
    chk("R6 no probe after ready", gate_seen, 0);
    chk("R6 ready stays", rail_ready, 1);

    // R7 partial count discarded on disable
    dis_n = 1'b0; cyc(2);
    chk("R7 ready cleared by disable", rail_ready, 0);
    dis_n = 1'b1; cyc(2);
    toggle_sw(); toggle_sw(); toggle_sw();
    dis_n = 1'b0; cyc(2); dis_n = 1'b1; cyc(2);
    toggle_sw(); cyc(4);
    chk("R7 count cleared by disable", rail_ready, 0);
    toggle_sw(); toggle_sw(); toggle_sw();
    chk("R7 full new set ready", rail_ready, 1);

    // R7 partial count discarded on bias loss
    bias_ok = 1'b0; cyc(2); bias_ok = 1'b1; cyc(2);
    toggle_sw(); toggle_sw(); toggle_sw();
    bias_ok = 1'b0; cyc(2); bias_ok = 1'b1; cyc(2);
    toggle_sw(); cyc(4);
    chk("R7 count cleared by bias loss", rail_ready, 0);

    // R8 changes while idle ignored
    dis_n = 1'b0; cyc(2);
    toggle_sw(); toggle_sw(); toggle_sw(); toggle_sw(); toggle_sw();
    dis_n = 1'b1; cyc(10);
    chk("R8 idle crossings ignored", rail_ready, 0);

    finish_run();
  end

  initial begin
    for (int n = 0; n < 20000; n++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    finish_run();
  end
endmodule